// File: doc/BRIEF.md
# Banked Cartridge Memory Controller

This block sits between a processor's 16-bit address bus and a large read-only program store with an optional battery-backed data RAM. The processor sees only 32 KiB of program space and an 8 KiB data window. The controller widens that view by banking. The lower 16 KiB of program space always shows the first bank. The upper 16 KiB shows a selectable bank. The data window shows one of four selectable RAM pages.

The program area cannot be written, so stores into it are taken as control writes. Which quarter of the program area a store lands in selects the control field it changes: the RAM gate, the program bank, the RAM page or the mode flag.

Reads pass through without delay. The controller combines the processor address with the stored bank fields to form the physical program address and the physical RAM address. It also steers the data that comes back. The processor bus is a plain strobe interface with no back-pressure: a read finishes in the cycle it is issued, and a write is taken on the clock edge that ends its cycle. Two static inputs set the configuration: the number of program banks fitted, and whether a RAM is fitted.

Top module: `cart_bank_ctrl`

## Requirements
- R1: After reset the stored program bank is 1, the RAM page is 0, the RAM gate is closed and `mode_adv` is 0.
- R2: A write to 0x0000–0x1FFF opens the RAM gate when data bits [3:0] equal 0xA and closes it for any other value. When `cfg_ram_present` is 0, the write leaves the gate unchanged.
- R3: A write to 0x2000–0x3FFF stores data bits [4:0] as the program bank. A stored value of 0 selects bank 1.
- R4: The program bank driven in `rom_addr[18:14]` is limited to `cfg_rom_banks` minus one. A count of 0 selects bank 0.
- R5: A write to 0x4000–0x5FFF stores data bits [1:0] as the RAM page. `ram_addr` is the page in bits [14:13] and the CPU address bits [12:0] below it.
- R6: A write to 0x6000–0x7FFF sets `mode_adv` from data bit 0. No other access changes it.
- R7: Reads of 0x0000–0x3FFF drive `rom_addr` with the CPU address, with bits [18:14] at zero, and return `rom_rdata`.
- R8: Reads of 0x4000–0x7FFF drive `rom_addr` with the limited bank in bits [18:14] and CPU address bits [13:0] below it, and return `rom_rdata`.
- R9: Reads of 0xA000–0xBFFF return `ram_rdata` only when the gate is open and a RAM is present; otherwise they return 0xFF.
- R10: `ram_we` is high only during a write to 0xA000–0xBFFF while the gate is open and a RAM is present. `ram_wdata` carries the CPU write data.
- R11: Reads of 0x8000–0x9FFF and 0xC000–0xFFFF return 0xFF. Writes there change no control field.
- R12: A control write takes effect from the clock edge that ends its cycle. Address mapping is combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | Processor address |
| cpu_wdata | input | 8 | Processor write data |
| cpu_rd | input | 1 | Read strobe |
| cpu_wr | input | 1 | Write strobe |
| cpu_rdata | output | 8 | Read data to processor |
| cfg_rom_banks | input | 6 | Number of 16 KiB program banks fitted |
| cfg_ram_present | input | 1 | A data RAM is fitted |
| rom_addr | output | 19 | Physical program-store address |
| rom_rdata | input | 8 | Program-store read data |
| ram_addr | output | 15 | Physical RAM address |
| ram_we | output | 1 | RAM write enable |
| ram_wdata | output | 8 | RAM write data |
| ram_rdata | input | 8 | RAM read data |
| mode_adv | output | 1 | Banking mode flag |

## Verification
The assertions check these properties on every cycle:
- the fixed-bank mapping;
- the limit on the program bank;
- the ban on bank 0 in the switchable window;
- the gating of the RAM write enable;
- the 0xFF return for an absent RAM and for unmapped addresses;
- the RAM offset bits;
- the rule that only a mode write moves `mode_adv`.

Other behaviours can only be shown by the bench's scenarios, because they depend on history:
- whether a closed gate really drops a write and leaves the old RAM contents in place;
- whether a gate write made while no RAM is fitted is ignored;
- the exact RAM page used;
- the cycle in which a control write first takes effect.

// File: rtl/cbc_pkg.sv
package cbc_pkg;
  localparam int CPU_ADDR_W = 16;

  typedef enum logic [2:0] {
    RG_GATE    = 3'd0,
    RG_ROMBANK = 3'd1,
    RG_RAMPAGE = 3'd2,
    RG_MODE    = 3'd3,
    RG_HOLE    = 3'd4,
    RG_RAMWIN  = 3'd5,
    RG_HIGH    = 3'd6
  } region_e;

  // Upper three address bits select an 8 KiB slice of the bus
  function automatic region_e classify(input logic [2:0] top);
    case (top)
      3'd0:    classify = RG_GATE;
      3'd1:    classify = RG_ROMBANK;
      3'd2:    classify = RG_RAMPAGE;
      3'd3:    classify = RG_MODE;
      3'd4:    classify = RG_HOLE;
      3'd5:    classify = RG_RAMWIN;
      default: classify = RG_HIGH;
    endcase
  endfunction
endpackage

// File: rtl/cbc_decode.sv
module cbc_decode
  import cbc_pkg::*;
#(
  parameter int N_CTRL = 4
) (
  input  logic [2:0]        addr_top,
  input  logic              cpu_wr,
  output region_e           region,
  output logic [N_CTRL-1:0] ctrl_wr,
  output logic              in_fixed,
  output logic              in_switch,
  output logic              in_ramwin
);
  assign region    = classify(addr_top);
  assign in_fixed  = (addr_top[2:1] == 2'b00);
  assign in_switch = (addr_top[2:1] == 2'b01);
  assign in_ramwin = (region == RG_RAMWIN);

  // One write strobe per control slice; slice index equals region code
  for (genvar gi = 0; gi < N_CTRL; gi++) begin : g_strobe
    assign ctrl_wr[gi] = cpu_wr && (region == region_e'(gi));
  end
endmodule

// File: rtl/cbc_regs.sv
module cbc_regs #(
  parameter int ROM_BANK_W = 5,
  parameter int RAM_BANK_W = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [3:0]            ctrl_wr,
  input  logic [ROM_BANK_W-1:0] wdata_lo,
  input  logic                  ram_present,
  output logic                  gate_open,
  output logic [ROM_BANK_W-1:0] rom_bank_raw,
  output logic [RAM_BANK_W-1:0] ram_page,
  output logic                  mode_flag
);
  localparam logic [3:0] GATE_KEY = 4'hA;
  localparam logic [ROM_BANK_W-1:0] BANK_RST = ROM_BANK_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_open    <= 1'b0;
      rom_bank_raw <= BANK_RST;
      ram_page     <= '0;
      mode_flag    <= 1'b0;
    end else begin
      if (ctrl_wr[0] && ram_present)
        gate_open <= (wdata_lo[3:0] == GATE_KEY);
      if (ctrl_wr[1])
        rom_bank_raw <= wdata_lo;
      if (ctrl_wr[2])
        ram_page <= wdata_lo[RAM_BANK_W-1:0];
      if (ctrl_wr[3])
        mode_flag <= wdata_lo[0];
    end
  end
endmodule

// File: rtl/cbc_map.sv
module cbc_map #(
  parameter int ROM_BANK_W = 5,
  parameter int RAM_BANK_W = 2,
  parameter int ROM_OFS_W  = 14,
  parameter int RAM_OFS_W  = 13,
  parameter int DATA_W     = 8
) (
  input  logic [ROM_OFS_W-1:0]            offset,
  input  logic                            in_fixed,
  input  logic                            in_switch,
  input  logic                            in_ramwin,
  input  logic                            cpu_rd,
  input  logic                            cpu_wr,
  input  logic [ROM_BANK_W-1:0]           rom_bank_raw,
  input  logic [RAM_BANK_W-1:0]           ram_page,
  input  logic [ROM_BANK_W:0]             bank_count,
  input  logic                            gate_open,
  input  logic                            ram_present,
  input  logic [DATA_W-1:0]               rom_rdata,
  input  logic [DATA_W-1:0]               ram_rdata,
  output logic [ROM_BANK_W+ROM_OFS_W-1:0] rom_addr,
  output logic [RAM_BANK_W+RAM_OFS_W-1:0] ram_addr,
  output logic                            ram_we,
  output logic [DATA_W-1:0]               cpu_rdata
);
  localparam int CNT_W = ROM_BANK_W + 1;

  logic [CNT_W-1:0]      limit;
  logic [ROM_BANK_W-1:0] bank_fixed;
  logic [ROM_BANK_W-1:0] bank_eff;
  logic                  ram_live;

  // Bank 0 is never shown in the switchable window; then cap to the fitted count
  always_comb begin
    limit      = (bank_count == '0) ? '0 : bank_count - CNT_W'(1);
    bank_fixed = (rom_bank_raw == '0) ? ROM_BANK_W'(1) : rom_bank_raw;
    bank_eff   = ({1'b0, bank_fixed} > limit) ? limit[ROM_BANK_W-1:0] : bank_fixed;
  end

  assign rom_addr = in_switch ? {bank_eff, offset} : {{ROM_BANK_W{1'b0}}, offset};
  assign ram_addr = {ram_page, offset[RAM_OFS_W-1:0]};
  assign ram_live = gate_open && ram_present;
  assign ram_we   = cpu_wr && in_ramwin && ram_live;

  always_comb begin
    cpu_rdata = '1;
    if (cpu_rd) begin
      if (in_fixed || in_switch)
        cpu_rdata = rom_rdata;
      else if (in_ramwin && ram_live)
        cpu_rdata = ram_rdata;
    end
  end
endmodule

// File: rtl/cart_bank_ctrl.sv
module cart_bank_ctrl
  import cbc_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int ROM_BANK_W = 5,
  parameter int RAM_BANK_W = 2,
  parameter int ROM_OFS_W  = 14,
  parameter int RAM_OFS_W  = 13
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [CPU_ADDR_W-1:0]           cpu_addr,
  input  logic [DATA_W-1:0]               cpu_wdata,
  input  logic                            cpu_rd,
  input  logic                            cpu_wr,
  output logic [DATA_W-1:0]               cpu_rdata,
  input  logic [ROM_BANK_W:0]             cfg_rom_banks,
  input  logic                            cfg_ram_present,
  output logic [ROM_BANK_W+ROM_OFS_W-1:0] rom_addr,
  input  logic [DATA_W-1:0]               rom_rdata,
  output logic [RAM_BANK_W+RAM_OFS_W-1:0] ram_addr,
  output logic                            ram_we,
  output logic [DATA_W-1:0]               ram_wdata,
  input  logic [DATA_W-1:0]               ram_rdata,
  output logic                            mode_adv
);
  localparam int N_CTRL = 4;

  region_e               region;
  logic [N_CTRL-1:0]     ctrl_wr;
  logic                  in_fixed, in_switch, in_ramwin;
  logic                  gate_open;
  logic [ROM_BANK_W-1:0] rom_bank_raw;
  logic [RAM_BANK_W-1:0] ram_page;

  cbc_decode #(.N_CTRL(N_CTRL)) u_decode (
    .addr_top  (cpu_addr[CPU_ADDR_W-1 -: 3]),
    .cpu_wr    (cpu_wr),
    .region    (region),
    .ctrl_wr   (ctrl_wr),
    .in_fixed  (in_fixed),
    .in_switch (in_switch),
    .in_ramwin (in_ramwin)
  );

  cbc_regs #(.ROM_BANK_W(ROM_BANK_W), .RAM_BANK_W(RAM_BANK_W)) u_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .ctrl_wr      (ctrl_wr),
    .wdata_lo     (cpu_wdata[ROM_BANK_W-1:0]),
    .ram_present  (cfg_ram_present),
    .gate_open    (gate_open),
    .rom_bank_raw (rom_bank_raw),
    .ram_page     (ram_page),
    .mode_flag    (mode_adv)
  );

  cbc_map #(
    .ROM_BANK_W (ROM_BANK_W),
    .RAM_BANK_W (RAM_BANK_W),
    .ROM_OFS_W  (ROM_OFS_W),
    .RAM_OFS_W  (RAM_OFS_W),
    .DATA_W     (DATA_W)
  ) u_map (
    .offset       (cpu_addr[ROM_OFS_W-1:0]),
    .in_fixed     (in_fixed),
    .in_switch    (in_switch),
    .in_ramwin    (in_ramwin),
    .cpu_rd       (cpu_rd),
    .cpu_wr       (cpu_wr),
    .rom_bank_raw (rom_bank_raw),
    .ram_page     (ram_page),
    .bank_count   (cfg_rom_banks),
    .gate_open    (gate_open),
    .ram_present  (cfg_ram_present),
    .rom_rdata    (rom_rdata),
    .ram_rdata    (ram_rdata),
    .rom_addr     (rom_addr),
    .ram_addr     (ram_addr),
    .ram_we       (ram_we),
    .cpu_rdata    (cpu_rdata)
  );

  assign ram_wdata = cpu_wdata;
endmodule

// File: rtl/cbc_checker.sv
module cbc_checker (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] cpu_addr,
  input logic        cpu_rd,
  input logic        cpu_wr,
  input logic [7:0]  cpu_rdata,
  input logic [5:0]  cfg_rom_banks,
  input logic        cfg_ram_present,
  input logic [18:0] rom_addr,
  input logic [14:0] ram_addr,
  input logic        ram_we,
  input logic        mode_adv
);
  AST_FIXED_ROM: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_addr[15:14] == 2'b00) |-> (rom_addr == {5'd0, cpu_addr[13:0]})); // R7

  AST_BANK_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_addr[15:14] == 2'b01 && cfg_rom_banks != 6'd0)
      |-> ({1'b0, rom_addr[18:14]} < cfg_rom_banks)); // R4

  AST_BANK_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_addr[15:14] == 2'b01 && cfg_rom_banks >= 6'd2) |-> (rom_addr[18:14] != 5'd0)); // R3

  AST_SWITCH_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_addr[15:14] == 2'b01) |-> (rom_addr[13:0] == cpu_addr[13:0])); // R8

  AST_RAM_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_addr[15:13] == 3'b101) |-> (ram_addr[12:0] == cpu_addr[12:0])); // R5

  AST_RAM_WE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> (cpu_wr && cpu_addr[15:13] == 3'b101 && cfg_ram_present)); // R10

  AST_RAM_ABSENT_FF: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rd && cpu_addr[15:13] == 3'b101 && !cfg_ram_present) |-> (cpu_rdata == 8'hFF)); // R9

  AST_UNMAPPED_FF: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rd && (cpu_addr[15:13] == 3'b100 || cpu_addr[15:14] == 2'b11))
      |-> (cpu_rdata == 8'hFF)); // R11

  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(cpu_wr && cpu_addr[15:13] == 3'b011) |=> $stable(mode_adv)); // R6
endmodule

bind cart_bank_ctrl cbc_checker i_cbc_checker (
  .clk             (clk),
  .rst_n           (rst_n),
  .cpu_addr        (cpu_addr),
  .cpu_rd          (cpu_rd),
  .cpu_wr          (cpu_wr),
  .cpu_rdata       (cpu_rdata),
  .cfg_rom_banks   (cfg_rom_banks),
  .cfg_ram_present (cfg_ram_present),
  .rom_addr        (rom_addr),
  .ram_addr        (ram_addr),
  .ram_we          (ram_we),
  .mode_adv        (mode_adv)
);

// File: tb/test_cart_bank_ctrl.sv
module test_cart_bank_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic        cpu_rd = 1'b0;
  logic        cpu_wr = 1'b0;
  logic [7:0]  cpu_rdata;
  logic [5:0]  cfg_rom_banks = 6'd32;
  logic        cfg_ram_present = 1'b1;
  logic [18:0] rom_addr;
  logic [7:0]  rom_rdata;
  logic [14:0] ram_addr;
  logic        ram_we;
  logic [7:0]  ram_wdata;
  logic [7:0]  ram_rdata;
  logic        mode_adv;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  // Bench's own model of the control fields
  logic       m_gate;
  logic [4:0] m_bank;
  logic [1:0] m_page;
  logic       m_mode;
  logic [7:0] exp_ram [0:1023];
  logic [7:0] dut_ram [0:1023];

  always #(CLK_PERIOD/2) clk = ~clk;

  cart_bank_ctrl i_cart_bank_ctrl (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_rdata(cpu_rdata),
    .cfg_rom_banks(cfg_rom_banks), .cfg_ram_present(cfg_ram_present),
    .rom_addr(rom_addr), .rom_rdata(rom_rdata), .ram_addr(ram_addr),
    .ram_we(ram_we), .ram_wdata(ram_wdata), .ram_rdata(ram_rdata),
    .mode_adv(mode_adv)
  );

  function automatic logic [7:0] rom_val(input logic [18:0] a);
    return a[7:0] ^ {a[18:14], 3'b101};
  endfunction

  function automatic int fold(input logic [14:0] a);
    return int'({a[14:13], a[7:0]});
  endfunction

  assign rom_rdata = rom_val(rom_addr);
  assign ram_rdata = dut_ram[fold(ram_addr)];
  always @(posedge clk) if (ram_we) dut_ram[fold(ram_addr)] <= ram_wdata;

  function automatic logic [4:0] exp_bank();
    logic [4:0] fix;
    logic [5:0] lim;
    fix = (m_bank == 5'd0) ? 5'd1 : m_bank;
    lim = (cfg_rom_banks == 6'd0) ? 6'd0 : cfg_rom_banks - 6'd1;
    return ({1'b0, fix} > lim) ? lim[4:0] : fix;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual %0h expected %0h (addr %h)", tag, act, exp, cpu_addr);
    end
  endtask

  task automatic model_reset();
    m_gate = 1'b0; m_bank = 5'd1; m_page = 2'd0; m_mode = 1'b0;
  endtask

  task automatic do_write(input logic [15:0] a, input logic [7:0] d);
    logic we_exp;
    @(negedge clk);
    cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1; cpu_rd = 1'b0;
    #1;
    we_exp = (a[15:13] == 3'b101) && m_gate && cfg_ram_present;
    chk("R10 ram_we", 32'(ram_we), 32'(we_exp));
    if (we_exp) begin
      chk("R5 ram_addr", 32'(ram_addr), 32'({m_page, a[12:0]}));
      chk("R10 ram_wdata", 32'(ram_wdata), 32'(d));
    end
    @(posedge clk);
    case (a[15:13])
      3'd0: if (cfg_ram_present) m_gate = (d[3:0] == 4'hA);
      3'd1: m_bank = d[4:0];
      3'd2: m_page = d[1:0];
      3'd3: m_mode = d[0];
      3'd5: if (we_exp) exp_ram[fold({m_page, a[12:0]})] = d;
      default: ;
    endcase
    #1;
    cpu_wr = 1'b0;
    chk("R6 mode_adv", 32'(mode_adv), 32'(m_mode));
  endtask

  task automatic do_read(input logic [15:0] a);
    logic [18:0] ea;
    logic [7:0]  ed;
    @(negedge clk);
    cpu_addr = a; cpu_rd = 1'b1; cpu_wr = 1'b0;
    #1;
    if (a[15] == 1'b0) begin
      ea = a[14] ? {exp_bank(), a[13:0]} : {5'd0, a[13:0]};
      chk(a[14] ? "R8 rom_addr" : "R7 rom_addr", 32'(rom_addr), 32'(ea));
      chk(a[14] ? "R8 rdata" : "R7 rdata", 32'(cpu_rdata), 32'(rom_val(ea)));
    end else if (a[15:13] == 3'b101) begin
      chk("R5 ram_addr", 32'(ram_addr), 32'({m_page, a[12:0]}));
      ed = (m_gate && cfg_ram_present) ? exp_ram[fold({m_page, a[12:0]})] : 8'hFF;
      chk("R9 ram rdata", 32'(cpu_rdata), 32'(ed));
    end else begin
      chk("R11 unmapped rdata", 32'(cpu_rdata), 32'hFF);
    end
    @(posedge clk);
    #1 cpu_rd = 1'b0;
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) begin
      dut_ram[i] = 8'h00;
      exp_ram[i] = 8'h00;
    end
    model_reset();
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1: reset state seen at the ports
    chk("R1 mode_adv", 32'(mode_adv), 32'd0);
    do_read(16'h4000);
    chk("R1 bank after reset", 32'(rom_addr[18:14]), 32'd1);
    do_read(16'hA010);
    chk("R1 gate closed", 32'(cpu_rdata), 32'hFF);

    // R3: bank 0 selects bank 1; low five bits only
    do_write(16'h2100, 8'h00); do_read(16'h7FFF);
    do_write(16'h3FFF, 8'hE7); do_read(16'h4123);
    chk("R3 upper bits dropped", 32'(rom_addr[18:14]), 32'd7);

    // R4: limit against the fitted count
    cfg_rom_banks = 6'd4;
    do_write(16'h2000, 8'h1F); do_read(16'h5555);
    chk("R4 clamp", 32'(rom_addr[18:14]), 32'd3);
    cfg_rom_banks = 6'd1; do_read(16'h4001);
    chk("R4 single bank", 32'(rom_addr[18:14]), 32'd0);
    cfg_rom_banks = 6'd32;

    // R2: gate write ignored with no RAM fitted
    cfg_ram_present = 1'b0;
    do_write(16'h0000, 8'h0A);
    do_read(16'hA000);
    cfg_ram_present = 1'b1;
    do_read(16'hA000);
    chk("R2 ignored without RAM", 32'(cpu_rdata), 32'hFF);

    // R2/R5/R10: open, write two pages, close, verify drop
    do_write(16'h1234, 8'hFA);
    do_write(16'h4000, 8'hFE);
    do_write(16'hA042, 8'h5C);
    do_write(16'h5FFF, 8'h01);
    do_write(16'hA042, 8'hC3);
    do_read(16'hA042);
    do_write(16'h4000, 8'h02); do_read(16'hA042);
    chk("R5 page 2 data", 32'(cpu_rdata), 32'h5C);
    do_write(16'h0000, 8'h0B);
    do_write(16'hA042, 8'h99);
    do_write(16'h0000, 8'hBA);
    do_read(16'hA042);
    chk("R2 dropped while closed", 32'(cpu_rdata), 32'h5C);

    // R12: page change visible only after the ending edge
    @(negedge clk);
    cpu_addr = 16'h4000; cpu_wdata = 8'h03; cpu_wr = 1'b1;
    #1 chk("R12 before edge", 32'(ram_addr[14:13]), 32'(m_page));
    @(posedge clk); m_page = 2'd3;
    #1 chk("R12 after edge", 32'(ram_addr[14:13]), 32'd3);
    cpu_wr = 1'b0;

    // R6/R11: mode flag; unmapped areas
    do_write(16'h6000, 8'hFF);
    do_write(16'h7ABC, 8'h02);
    do_write(16'h6001, 8'h01);
    do_write(16'h8000, 8'h00);
    do_write(16'hC000, 8'h1A);
    do_read(16'h9FFF); do_read(16'hC000); do_read(16'hFFFF);
    do_read(16'h4000);
    chk("R11 unmapped write kept bank", 32'(rom_addr[18:14]), 32'(exp_bank()));

    // Constrained random phase
    void'($urandom(32'd2718));
    for (int it = 0; it < 4000; it++) begin
      int unsigned op;
      logic [15:0] a;
      logic [7:0]  d;
      if (it % 500 == 0) begin
        case ((it / 500) % 6)
          0: cfg_rom_banks = 6'd32;
          1: cfg_rom_banks = 6'd8;
          2: cfg_rom_banks = 6'd5;
          3: cfg_rom_banks = 6'd2;
          4: cfg_rom_banks = 6'd0;
          default: cfg_rom_banks = 6'd16;
        endcase
        cfg_ram_present = ($urandom % 4) != 0;
      end
      op = $urandom % 8;
      a  = 16'($urandom);
      d  = 8'($urandom);
      case (op)
        0: do_write({3'd0, a[12:0]}, ($urandom % 2) ? {d[7:4], 4'hA} : d);
        1: do_write({3'd1, a[12:0]}, d);
        2: do_write({3'd2, a[12:0]}, d);
        3: do_write({3'd3, a[12:0]}, d);
        4: do_write({3'd5, 5'd0, a[7:0]}, d);
        5: do_read({3'd5, 5'd0, a[7:0]});
        6: do_read({1'b0, a[14:0]});
        default: do_read(a);
      endcase
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end
endmodule